// File: doc/BRIEF.md
# SPI Slave Register-Access Bridge

This block lets an external SPI master read and write a bank of 8-bit registers inside the chip. The SPI pins (clock, active-low select and master-out data) are brought into the faster system-clock domain through two-flop synchronizers. All protocol decoding happens on edges of the synchronized serial clock. Clock polarity and clock phase are both configuration inputs, so any of the four SPI modes can be used.

A transaction opens with a device byte. Its upper seven bits must equal the configured slave address, and its lowest bit chooses the direction. The next byte is the register index. Any number of data bytes can follow. In a write, every complete data byte becomes a one-cycle write strobe on the register port. In a read, the bridge shifts register contents out on the slave-out line. The register index steps by one after each data byte in both directions. A read-latency option makes the bridge send one byte of zeros before the read data, which gives slow register paths more time.

When the device address does not match, the bridge ignores the rest of the transaction. Raising the select line ends a transaction at any point and discards any incomplete byte.

Top module: `spi_regbridge`

## Requirements
- R1: MOSI is sampled on the rising SCK edge when CPOL equals CPHA and on the falling edge otherwise. MISO changes only on the opposite edge. CPOL=0 means SCK idles low, and CPOL=1 means it idles high. All four combinations give the same register results.
- R2: Bits [7:1] of the first byte are compared with `cfg_dev_addr`. On a mismatch the transaction causes no register write, and `spi_miso_oe` stays low until the select line rises.
- R3: Bit [0] of the first byte is 1 for a read and 0 for a write. A read transaction never issues a write strobe.
- R4: The second byte sets the register address. In a write, each complete data byte, received MSB first, produces a write strobe with `reg_wdata` equal to that byte.
- R5: Data byte k of a transaction goes to address (subaddress + k) mod 256, so the address wraps from 0xFF to 0x00. `reg_addr` holds steady during a write strobe.
- R6: With `cfg_rd_delay`=0, the bits that immediately follow the subaddress carry the contents of the addressed registers, MSB first, one byte for each consecutive address.
- R7: With `cfg_rd_delay`=1, the slave first drives eight 0 bits and then the read data, as in R6.
- R8: A high level on `spi_cs_n` ends the transaction. A partially received byte is never written, and `spi_miso_oe` falls within a few system clocks.
- R9: `reg_we` is a pulse of a single cycle, issued only after all 8 bits of a data byte have been sampled.
- R10: `spi_miso_oe` is high only during the dummy and data bytes of a matched read. It stays low during the device and subaddress bytes and throughout a write.
- R11: While reset is active, `reg_we` and `spi_miso_oe` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Clock phase: 0 samples on the leading edge, 1 on the trailing edge |
| cfg_rd_delay | input | 1 | 1 inserts a dummy byte before read data |
| cfg_dev_addr | input | 7 | Slave address matched against the first byte |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | MISO drive enable; the pad is tri-stated when low |
| reg_addr | output | 8 | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | Register file write strobe |
| reg_rdata | input | 8 | Register file read data, combinational from reg_addr |

## Verification
A pin change becomes a sample or shift event three system clocks later: two synchronizer stages plus the edge compare. A write strobe follows the event for the last bit of a data byte by one cycle, and the address steps one cycle after that. A MISO bit is updated one cycle after its shift event. The bench holds each SCK level for 16 system clocks and reads MISO just before it toggles the sampling edge. That leaves more than ten cycles of margin over the four-cycle response. Register contents and strobe counts are checked only after the select line has been high for eight cycles, when every pending write has landed.

// File: rtl/spi_regbridge_pkg.sv
package spi_regbridge_pkg;

  localparam int BYTE_W = 8;
  localparam int DEV_W  = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    PH_DEV    = 3'd0,
    PH_SUB    = 3'd1,
    PH_DUMMY  = 3'd2,
    PH_DATA   = 3'd3,
    PH_IGNORE = 3'd4
  } phase_e;

  // sampling edge is the rising one whenever polarity and phase agree
  function automatic logic samples_on_rise(input logic cpol, input logic cpha);
    return cpol == cpha;
  endfunction

  function automatic logic dev_match(input logic [DEV_W-1:0] got,
                                     input logic [DEV_W-1:0] want);
    return got == want;
  endfunction

  function automatic logic [BYTE_W-1:0] next_ptr(input logic [BYTE_W-1:0] p);
    return p + 1'b1;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/spi_edge_detect.sv
module spi_edge_detect
  import spi_regbridge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_s,
  input  logic cpol,
  input  logic cpha,
  output logic sample_evt,
  output logic shift_evt
);

  logic sck_d;
  logic rise, fall, on_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign rise    = sck_s & ~sck_d;
  assign fall    = ~sck_s & sck_d;
  assign on_rise = samples_on_rise(cpol, cpha);

  assign sample_evt = ~cs_s & (on_rise ? rise : fall);
  assign shift_evt  = ~cs_s & (on_rise ? fall : rise);

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_regbridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              mosi_s,
  input  logic              sample_evt,
  input  logic              shift_evt,
  input  logic              rd_delay,
  input  logic [DEV_W-1:0]  dev_addr,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              load_evt,
  output logic              dummy_evt,
  output logic              read_phase,
  output logic              rw_read,
  output logic              ignored
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] byte_in;
  logic [BYTE_W-1:0] ptr_q;
  logic              rw_q;
  logic              we_q;
  logic [BYTE_W-1:0] wdata_q;
  logic              byte_done;

  assign byte_in   = {rx_q[BYTE_W-2:0], mosi_s};
  assign byte_done = sample_evt && (bit_cnt_q == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_DEV;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
    end else if (cs_s) begin
      phase_q   <= PH_DEV;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      rw_q      <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (we_q || load_evt) ptr_q <= next_ptr(ptr_q);
      if (sample_evt) begin
        rx_q      <= byte_in;
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
      if (byte_done) begin
        unique case (phase_q)
          PH_DEV: begin
            if (dev_match(byte_in[BYTE_W-1:1], dev_addr)) begin
              phase_q <= PH_SUB;
              rw_q    <= byte_in[0];
            end else begin
              phase_q <= PH_IGNORE;
            end
          end
          PH_SUB: begin
            ptr_q   <= byte_in;
            phase_q <= (rw_q && rd_delay) ? PH_DUMMY : PH_DATA;
          end
          PH_DUMMY: phase_q <= PH_DATA;
          PH_DATA: begin
            if (!rw_q) begin
              we_q    <= 1'b1;
              wdata_q <= byte_in;
            end
          end
          default: phase_q <= PH_IGNORE;
        endcase
      end
    end
  end

  assign load_evt   = shift_evt && (phase_q == PH_DATA) && rw_q && (bit_cnt_q == '0);
  assign dummy_evt  = shift_evt && (phase_q == PH_DUMMY) && (bit_cnt_q == '0);
  assign read_phase = rw_q && ((phase_q == PH_DUMMY) || (phase_q == PH_DATA));
  assign rw_read    = rw_q;
  assign ignored    = (phase_q == PH_IGNORE);

  assign reg_addr  = ptr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;

endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path
  import spi_regbridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              shift_evt,
  input  logic              load_evt,
  input  logic              dummy_evt,
  input  logic              read_phase,
  input  logic [BYTE_W-1:0] rdata,
  output logic              miso,
  output logic              miso_oe
);

  logic [BYTE_W-1:0] sr_q;
  logic              miso_q;
  logic              oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      miso_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (cs_s) begin
      sr_q   <= '0;
      miso_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (shift_evt && read_phase) begin
      oe_q <= 1'b1;
      if (load_evt) begin
        miso_q <= rdata[BYTE_W-1];
        sr_q   <= {rdata[BYTE_W-2:0], 1'b0};
      end else if (dummy_evt) begin
        miso_q <= 1'b0;
        sr_q   <= '0;
      end else begin
        miso_q <= sr_q[BYTE_W-1];
        sr_q   <= {sr_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign miso    = miso_q;
  assign miso_oe = oe_q;

endmodule

// File: rtl/spi_regbridge.sv
module spi_regbridge
  import spi_regbridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_rd_delay,
  input  logic [DEV_W-1:0]  cfg_dev_addr,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);

  logic [2:0] pins_s;
  logic sck_s, cs_s, mosi_s;
  logic sample_evt, shift_evt;
  logic load_evt, dummy_evt, read_phase, rw_read, ignored;

  // bit 2: select (idles high), bit 1: clock, bit 0: data
  spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_cs_n, spi_sck, spi_mosi}),
    .dout (pins_s)
  );

  assign cs_s   = pins_s[2];
  assign sck_s  = pins_s[1];
  assign mosi_s = pins_s[0];

  spi_edge_detect u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_s     (sck_s),
    .cs_s      (cs_s),
    .cpol      (cfg_cpol),
    .cpha      (cfg_cpha),
    .sample_evt(sample_evt),
    .shift_evt (shift_evt)
  );

  spi_frame_ctrl u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .mosi_s    (mosi_s),
    .sample_evt(sample_evt),
    .shift_evt (shift_evt),
    .rd_delay  (cfg_rd_delay),
    .dev_addr  (cfg_dev_addr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .load_evt  (load_evt),
    .dummy_evt (dummy_evt),
    .read_phase(read_phase),
    .rw_read   (rw_read),
    .ignored   (ignored)
  );

  spi_tx_path u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .shift_evt (shift_evt),
    .load_evt  (load_evt),
    .dummy_evt (dummy_evt),
    .read_phase(read_phase),
    .rdata     (reg_rdata),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe)
  );

endmodule

// File: rtl/spi_regbridge_chk.sv
module spi_regbridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       sample_evt,
  input logic       shift_evt,
  input logic       reg_we,
  input logic [7:0] reg_addr,
  input logic       miso,
  input logic       miso_oe,
  input logic       read_phase,
  input logic       rw_read,
  input logic       ignored
);

  p_miso_on_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && $past(miso_oe) && !$stable(miso)) |-> $past(shift_evt));

  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ignored |-> (!reg_we && !miso_oe));

  p_read_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !rw_read);

  p_we_after_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(sample_evt));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $stable(reg_addr));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!miso_oe && !reg_we));

  p_we_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_oe_read_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (read_phase && !ignored));

  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r11: assert (!reg_we && !miso_oe);
    end
  end

endmodule

bind spi_regbridge spi_regbridge_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_s      (cs_s),
  .sample_evt(sample_evt),
  .shift_evt (shift_evt),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .miso      (spi_miso),
  .miso_oe   (spi_miso_oe),
  .read_phase(read_phase),
  .rw_read   (rw_read),
  .ignored   (ignored)
);

// File: tb/spi_regbridge_test.sv
module spi_regbridge_test;

  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       cfg_cpol, cfg_cpha, cfg_rd_delay;
  logic [6:0] cfg_dev_addr;
  logic       sck, cs_n, mosi;
  logic       miso, miso_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we;

  logic [7:0] mem [256];
  int         we_pulses = 0;
  int         checks = 0;
  int         errors = 0;

  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];
  logic [7:0] dummy_rx;
  logic       hdr_oe, data_oe;

  spi_regbridge uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_rd_delay(cfg_rd_delay),
    .cfg_dev_addr(cfg_dev_addr),
    .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_pulses = we_pulses + 1;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic half();
    repeat (16) @(negedge clk);
  endtask

  // one bit as master; MISO read just before the sampling edge, pulled up when undriven
  task automatic xbit(input logic b, output logic r, output logic oe);
    if (!cfg_cpha) begin
      mosi = b;
      half();
      r  = miso_oe ? miso : 1'b1;
      oe = miso_oe;
      sck = ~sck;
      half();
      sck = ~sck;
    end else begin
      sck  = ~sck;
      mosi = b;
      half();
      r  = miso_oe ? miso : 1'b1;
      oe = miso_oe;
      sck = ~sck;
      half();
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_seen);
    oe_seen = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      logic r, o;
      xbit(tx[i], r, o);
      rx[i] = r;
      oe_seen |= o;
    end
  endtask

  task automatic start(input logic pol, input logic pha, input logic dly);
    cfg_cpol = pol; cfg_cpha = pha; cfg_rd_delay = dly;
    sck = pol; cs_n = 1'b1;
    repeat (8) @(negedge clk);
    cs_n = 1'b0;
    half();
  endtask

  task automatic stop();
    half();
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_xact(input logic pol, input logic pha, input logic dly,
                          input logic [6:0] dev, input logic rd,
                          input logic [7:0] sub, input int n);
    logic [7:0] junk;
    logic o1, o2, o;
    start(pol, pha, dly);
    xbyte({dev, rd}, junk, o1);
    xbyte(sub, junk, o2);
    hdr_oe  = o1 | o2;
    data_oe = 1'b0;
    dummy_rx = 8'hxx;
    if (rd && dly) begin
      xbyte(8'h00, dummy_rx, o);
      data_oe |= o;
    end
    for (int i = 0; i < n; i++) begin
      xbyte(rd ? 8'h00 : wbuf[i], rbuf[i], o);
      data_oe |= o;
    end
    stop();
  endtask

  task automatic t_write_basic();
    int p0 = we_pulses;
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
    run_xact(1, 1, 0, DEV, 0, 8'h10, 2);
    check("R4", "write byte0", mem[8'h10], 8'hA5);
    check("R5", "write byte1 next addr", mem[8'h11], 8'h3C);
    check("R9", "one strobe per byte", we_pulses - p0, 2);
    check("R10", "no drive in write", {hdr_oe, data_oe}, 2'b00);
  endtask

  task automatic t_read_nodelay();
    int p0 = we_pulses;
    run_xact(1, 1, 0, DEV, 1, 8'h10, 2);
    check("R6", "read byte0", rbuf[0], 8'hA5);
    check("R6", "read byte1", rbuf[1], 8'h3C);
    check("R10", "no drive in header", hdr_oe, 1'b0);
    check("R3", "read issues no strobe", we_pulses - p0, 0);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 3; m++) begin
      logic pol = m[1];
      logic pha = m[0];
      wbuf[0] = 8'h61 + 8'(m * 17);
      run_xact(pol, pha, 0, DEV, 0, 8'h20 + 8'(m), 1);
      check("R1", "mode write", mem[8'h20 + 8'(m)], 8'h61 + 8'(m * 17));
      run_xact(pol, pha, 0, DEV, 1, 8'h20 + 8'(m), 1);
      check("R1", "mode read", rbuf[0], 8'h61 + 8'(m * 17));
    end
  endtask

  task automatic t_delay();
    run_xact(1, 1, 1, DEV, 1, 8'h10, 2);
    check("R7", "dummy byte mode3", dummy_rx, 8'h00);
    check("R7", "delayed byte0", rbuf[0], 8'hA5);
    check("R7", "delayed byte1", rbuf[1], 8'h3C);
    run_xact(0, 0, 1, DEV, 1, 8'h11, 1);
    check("R7", "dummy byte mode0", dummy_rx, 8'h00);
    check("R7", "delayed mode0 data", rbuf[0], 8'h3C);
  endtask

  task automatic t_wrap();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    run_xact(0, 1, 0, DEV, 0, 8'hFF, 2);
    check("R5", "last address", mem[8'hFF], 8'h11);
    check("R5", "wrapped address", mem[8'h00], 8'h22);
  endtask

  task automatic t_mismatch();
    int p0 = we_pulses;
    wbuf[0] = 8'h77;
    run_xact(1, 1, 0, DEV ^ 7'h01, 0, 8'h40, 1);
    check("R2", "foreign write ignored", mem[8'h40], 8'h00);
    check("R2", "no strobe", we_pulses - p0, 0);
    run_xact(1, 1, 0, DEV ^ 7'h40, 1, 8'h10, 1);
    check("R2", "foreign read undriven", rbuf[0], 8'hFF);
    check("R2", "oe stays low", {hdr_oe, data_oe}, 2'b00);
  endtask

  task automatic t_abort();
    logic [7:0] junk;
    logic o;
    int p0 = we_pulses;
    start(1, 1, 0);
    xbyte({DEV, 1'b0}, junk, o);
    xbyte(8'h50, junk, o);
    xbyte(8'h99, junk, o);
    for (int i = 0; i < 4; i++) begin
      logic r, oe;
      xbit(1'b1, r, oe);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R8", "full byte kept", mem[8'h50], 8'h99);
    check("R8", "partial byte dropped", mem[8'h51], 8'h00);
    check("R8", "single strobe", we_pulses - p0, 1);
    start(1, 1, 0);
    xbyte({DEV, 1'b1}, junk, o);
    xbyte(8'h10, junk, o);
    xbyte(8'h00, junk, o);
    check("R6", "read before abort", junk, 8'hA5);
    for (int i = 0; i < 3; i++) begin
      logic r, oe;
      xbit(1'b0, r, oe);
    end
    check("R10", "oe high mid read", miso_oe, 1'b1);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R8", "oe released", miso_oe, 1'b0);
  endtask

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b1; mosi = 1'b0;
    cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_rd_delay = 1'b0; cfg_dev_addr = DEV;
    repeat (5) @(negedge clk);
    check("R11", "we in reset", reg_we, 1'b0);
    check("R11", "oe in reset", miso_oe, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_write_basic();
    t_read_nodelay();
    t_modes();
    t_delay();
    t_wrap();
    t_mismatch();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule